// File: doc/BRIEF.md
# Security-Banked Binary Point Register Slice

This block is the binary point part of one interrupt controller CPU interface, repeated for every CPU. Each CPU has two 3-bit point values. The primary copy serves secure software, or all software when the controller has no security support. The alias copy serves non-secure software and is also reachable through a second, aliased offset. A simple register port selects the CPU bank and gives a byte offset, write data, a write strobe and an attribute that marks the access as secure. The block returns the addressed value zero-extended to 32 bits.

Two static inputs configure the slice. One says whether security extensions are present. The other selects architecture revision 2 (high) or revision 1 (low). Together they decide which copy each access reaches, and which accesses read as zero and drop their writes. Interrupt groups exist when the revision is 2 or when security extensions are present. Arbitration, acknowledge and end-of-interrupt handling belong to other blocks.

Top module: `binpt_slice`

## Requirements
- R1: After reset every CPU's primary copy holds 2 and every alias copy holds 3.
- R2: A write keeps only wdata_i[2:0]. rdata_o[31:3] is always zero.
- R3: At offset 0x08, a non-secure access with security extensions present reads and writes the alias copy. Every other access at 0x08 reaches the primary copy.
- R4: A value written to the primary copy is stored as given, minimum 0. A value of 0 written to the alias copy is stored as 1, so the alias copy is never 0.
- R5: With revision 1 and no security extensions, offset 0x1c reads as zero and writes to it change no copy.
- R6: With security extensions present, a non-secure access to offset 0x1c reads as zero and its write changes no copy.
- R7: Offset 0x1c reads and writes the alias copy in two cases: a secure access with security extensions present, or any access with revision 2 and no security extensions.
- R8: cpu_idx_i selects the bank. A write changes only the copies of the addressed CPU.
- R9: Any offset other than 0x08 and 0x1c reads as zero, and a write to it changes no copy.
- R10: Read data follows the current request in the same cycle. A write becomes visible to reads from the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_idx_i | input | 2 | CPU bank select |
| offset_i | input | 12 | Byte offset within the CPU interface |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| secure_i | input | 1 | High for a secure access |
| sec_ext_i | input | 1 | Security extensions present (static) |
| rev2_i | input | 1 | High for revision 2, low for revision 1 (static) |
| rdata_o | output | 32 | Read data, zero-extended |

## Verification
The read path has no register, so each request's result is due in the same cycle. The bench drives every request just after a falling edge and compares rdata_o a little later, before the next rising edge. A write reaches storage at the following rising edge. The bench updates its reference model only after that edge, so any read in the next cycle must already show the new value. A read in the same cycle as the write must still show the old one.

// File: rtl/binpt_pkg.sv
package binpt_pkg;
  localparam int FIELD_W  = 3;
  localparam int OFF_W    = 12;
  localparam int DATA_W   = 32;
  localparam logic [OFF_W-1:0] OFF_POINT = 12'h008;
  localparam logic [OFF_W-1:0] OFF_ALIAS = 12'h01c;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_PRI   = 2'd1,
    TGT_ALIAS = 2'd2
  } tgt_e;
endpackage

// File: rtl/binpt_route.sv
module binpt_route
  import binpt_pkg::*;
(
  input  logic [OFF_W-1:0] offset_i,
  input  logic             secure_i,
  input  logic             sec_ext_i,
  input  logic             rev2_i,
  output tgt_e             tgt_o
);
  logic ns_banked;
  logic groups;

  assign ns_banked = sec_ext_i && !secure_i;
  assign groups    = rev2_i || sec_ext_i;

  always_comb begin
    tgt_o = TGT_NONE;
    if (offset_i == OFF_POINT) begin
      tgt_o = ns_banked ? TGT_ALIAS : TGT_PRI;
    end else if (offset_i == OFF_ALIAS) begin
      // alias offset: hidden without groups and from non-secure side
      if (groups && !ns_banked) tgt_o = TGT_ALIAS;
    end
  end
endmodule

// File: rtl/binpt_bank.sv
module binpt_bank #(
  parameter int NUM_CPU = 4,
  parameter int FW      = 3,
  parameter int RST_VAL = 2,
  parameter int MIN_VAL = 0,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [CPU_W-1:0]      cpu_i,
  input  logic [FW-1:0]         wval_i,
  output logic [NUM_CPU*FW-1:0] val_o
);
  logic [FW-1:0] wval_c;

  generate
    if (MIN_VAL == 0) begin : g_noclamp
      assign wval_c = wval_i;
    end else begin : g_clamp
      assign wval_c = (wval_i < FW'(MIN_VAL)) ? FW'(MIN_VAL) : wval_i;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
      logic [FW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= FW'(RST_VAL);
        end else if (we_i && (cpu_i == CPU_W'(k))) begin
          q <= wval_c;
        end
      end
      assign val_o[k*FW +: FW] = q;
    end
  endgenerate
endmodule

// File: rtl/binpt_slice.sv
module binpt_slice
  import binpt_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int PRI_RST   = 2,
  parameter int ALIAS_RST = 3,
  parameter int PRI_MIN   = 0,
  parameter int ALIAS_MIN = 1,
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_W-1:0]  cpu_idx_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              secure_i,
  input  logic              sec_ext_i,
  input  logic              rev2_i,
  output logic [DATA_W-1:0] rdata_o
);
  tgt_e                       tgt;
  logic [NUM_CPU*FIELD_W-1:0] pri_flat;
  logic [NUM_CPU*FIELD_W-1:0] alias_flat;
  logic [FIELD_W-1:0]         pri_sel;
  logic [FIELD_W-1:0]         alias_sel;

  binpt_route u_route (
    .offset_i  (offset_i),
    .secure_i  (secure_i),
    .sec_ext_i (sec_ext_i),
    .rev2_i    (rev2_i),
    .tgt_o     (tgt)
  );

  binpt_bank #(
    .NUM_CPU (NUM_CPU), .FW (FIELD_W), .RST_VAL (PRI_RST), .MIN_VAL (PRI_MIN)
  ) u_pri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i && (tgt == TGT_PRI)),
    .cpu_i  (cpu_idx_i),
    .wval_i (wdata_i[FIELD_W-1:0]),
    .val_o  (pri_flat)
  );

  binpt_bank #(
    .NUM_CPU (NUM_CPU), .FW (FIELD_W), .RST_VAL (ALIAS_RST), .MIN_VAL (ALIAS_MIN)
  ) u_alias (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i && (tgt == TGT_ALIAS)),
    .cpu_i  (cpu_idx_i),
    .wval_i (wdata_i[FIELD_W-1:0]),
    .val_o  (alias_flat)
  );

  assign pri_sel   = pri_flat[int'(cpu_idx_i)*FIELD_W +: FIELD_W];
  assign alias_sel = alias_flat[int'(cpu_idx_i)*FIELD_W +: FIELD_W];

  always_comb begin
    rdata_o = '0;
    unique case (tgt)
      TGT_PRI:   rdata_o[FIELD_W-1:0] = pri_sel;
      TGT_ALIAS: rdata_o[FIELD_W-1:0] = alias_sel;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/binpt_slice_chk.sv
module binpt_slice_chk
  import binpt_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [CPU_W-1:0]           cpu_idx_i,
  input logic [OFF_W-1:0]           offset_i,
  input logic                       we_i,
  input logic                       secure_i,
  input logic                       sec_ext_i,
  input logic                       rev2_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic [NUM_CPU*FIELD_W-1:0] pri_flat,
  input logic [NUM_CPU*FIELD_W-1:0] alias_flat
);
  logic off_other;
  assign off_other = (offset_i != OFF_POINT) && (offset_i != OFF_ALIAS);

  AST_RDATA_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:FIELD_W] == '0); // R2

  AST_NS_POINT_KEEPS_PRI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_POINT && sec_ext_i && !secure_i) |=> $stable(pri_flat)); // R3

  AST_V1_ALIAS_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_i == OFF_ALIAS && !rev2_i && !sec_ext_i) |-> rdata_o == '0); // R5

  AST_V1_ALIAS_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_ALIAS && !rev2_i && !sec_ext_i)
      |=> ($stable(pri_flat) && $stable(alias_flat))); // R5

  AST_NS_ALIAS_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_i == OFF_ALIAS && sec_ext_i && !secure_i) |-> rdata_o == '0); // R6

  AST_NS_ALIAS_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && offset_i == OFF_ALIAS && sec_ext_i && !secure_i)
      |=> ($stable(pri_flat) && $stable(alias_flat))); // R6

  AST_OTHER_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_other |-> rdata_o == '0); // R9

  AST_OTHER_WI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && off_other) |=> ($stable(pri_flat) && $stable(alias_flat))); // R9

  generate
    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
      AST_ALIAS_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alias_flat[k*FIELD_W +: FIELD_W] != '0); // R4

      AST_BANK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && cpu_idx_i != CPU_W'(k))
          |=> ($stable(pri_flat[k*FIELD_W +: FIELD_W])
               && $stable(alias_flat[k*FIELD_W +: FIELD_W]))); // R8
    end
  endgenerate
endmodule

bind binpt_slice binpt_slice_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_idx_i  (cpu_idx_i),
  .offset_i   (offset_i),
  .we_i       (we_i),
  .secure_i   (secure_i),
  .sec_ext_i  (sec_ext_i),
  .rev2_i     (rev2_i),
  .rdata_o    (rdata_o),
  .pri_flat   (pri_flat),
  .alias_flat (alias_flat)
);

// File: tb/binpt_slice_tb_top.sv
module binpt_slice_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cpu_idx_i = '0;
  logic [11:0] offset_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic        secure_i = 1'b0;
  logic        sec_ext_i = 1'b0;
  logic        rev2_i = 1'b1;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int m_pri[NCPU];
  int m_ali[NCPU];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  binpt_slice dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_idx_i (cpu_idx_i),
    .offset_i  (offset_i),
    .wdata_i   (wdata_i),
    .we_i      (we_i),
    .secure_i  (secure_i),
    .sec_ext_i (sec_ext_i),
    .rev2_i    (rev2_i),
    .rdata_o   (rdata_o)
  );

  // 0 = unmapped/hidden, 1 = primary, 2 = alias
  function automatic int which(int off, bit sec);
    bit ns_view = sec_ext_i && !sec;
    if (off == 'h08) return ns_view ? 2 : 1;
    if (off == 'h1c) begin
      if (!rev2_i && !sec_ext_i) return 0;
      if (ns_view) return 0;
      return 2;
    end
    return 0;
  endfunction

  task automatic access(int cpu, int off, logic [31:0] wd, bit we, bit sec, string req);
    int w, exp;
    @(negedge clk_i);
    cpu_idx_i = cpu[1:0]; offset_i = off[11:0]; wdata_i = wd; we_i = we; secure_i = sec;
    #1;
    w = which(off, sec);
    exp = (w == 1) ? m_pri[cpu] : (w == 2) ? m_ali[cpu] : 0;
    checks++;
    if (rdata_o !== 32'(exp)) begin
      errors++;
      $display("FAIL %s: cpu %0d off %0h sec %0b actual %0h expected %0h",
               req, cpu, off, sec, rdata_o, exp);
    end
    @(posedge clk_i);
    if (we) begin
      int v = int'(wd & 32'h7);
      if (w == 1) m_pri[cpu] = v;
      if (w == 2) m_ali[cpu] = (v < 1) ? 1 : v;
    end
    #1;
    we_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCPU; i++) begin m_pri[i] = 2; m_ali[i] = 3; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset values (rev2, no security: 0x1c exposes alias)
    for (int c = 0; c < NCPU; c++) begin
      access(c, 'h08, 0, 0, 1, "R1");
      access(c, 'h1c, 0, 0, 1, "R1");
    end
    // R2 only low bits kept, R10 next-cycle visibility
    access(0, 'h08, 32'hFFFF_FFFD, 1, 1, "R2");
    access(0, 'h08, 0, 0, 1, "R2_R10");
    // R4 clamping
    access(0, 'h08, 0, 1, 1, "R4");
    access(0, 'h08, 0, 0, 1, "R4");
    access(0, 'h1c, 32'h8, 1, 0, "R7");
    access(0, 'h1c, 0, 0, 0, "R4");
    access(0, 'h1c, 6, 1, 1, "R7");
    access(0, 'h1c, 0, 0, 0, "R7");
    // R8 bank isolation
    access(2, 'h08, 7, 1, 1, "R8");
    access(1, 'h08, 0, 0, 1, "R8");
    access(2, 'h08, 0, 0, 1, "R8");
    // security extensions present
    sec_ext_i = 1'b1;
    access(1, 'h08, 5, 1, 0, "R3");
    access(1, 'h08, 0, 0, 0, "R3");
    access(1, 'h08, 0, 0, 1, "R3");
    access(1, 'h1c, 0, 0, 1, "R3_R7");
    access(1, 'h08, 0, 1, 0, "R3_R4");
    access(1, 'h1c, 0, 0, 1, "R4");
    access(1, 'h1c, 4, 1, 0, "R6");
    access(1, 'h1c, 0, 0, 0, "R6");
    access(1, 'h1c, 0, 0, 1, "R6");
    access(1, 'h08, 0, 0, 1, "R6");
    // revision 1, no security
    sec_ext_i = 1'b0; rev2_i = 1'b0;
    access(3, 'h1c, 7, 1, 1, "R5");
    access(3, 'h1c, 0, 0, 1, "R5");
    access(3, 'h08, 6, 1, 0, "R3");
    rev2_i = 1'b1;
    access(3, 'h1c, 0, 0, 1, "R5");
    access(3, 'h08, 0, 0, 1, "R3");
    // R9 other offsets
    access(0, 'h0c, 7, 1, 1, "R9");
    access(0, 'h09, 7, 1, 1, "R9");
    access(0, 'h04, 7, 1, 0, "R9");
    access(0, 'h108, 7, 1, 1, "R9");
    access(0, 'h08, 0, 0, 1, "R9");
    access(0, 'h1c, 0, 0, 1, "R9");
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      int offs[4] = '{'h08, 'h1c, 'h08, 'h10};
      if (n % 100 == 0) begin
        sec_ext_i = $urandom_range(0, 1);
        rev2_i = $urandom_range(0, 1);
      end
      access($urandom_range(0, NCPU-1), offs[$urandom_range(0, 3)], $urandom,
             $urandom_range(0, 1), $urandom_range(0, 1), "R10");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule